// File: doc/BRIEF.md
# Two-Wire Serial Byte Master with Clock-Stretch Tolerance

This block drives a two-wire open-drain serial bus (clock and data lines, I2C-style) one byte operation at a time. It never drives either line high: each line has a pull-low enable, and a logic 1 appears only when the enable is removed and the external pull-up wins. A host issues one command at a time: START, STOP, WRITE a byte, READ a byte and acknowledge it, or READ a final byte and close the transfer with a STOP. Each command ends with a one-cycle done pulse carrying the received byte, the acknowledge seen after a write, and a timeout flag.

All bus timing comes from a one-microsecond tick input, so the same block works at any core clock. After every clock release the master waits for the clock line to read high. It polls every 2 µs, so a target that holds the clock low simply slows the transfer. If the line has not risen within 1000 µs, the command is abandoned, both lines are released, and the timeout flag is set. Every STOP is followed by 60 µs of idle bus before the command completes, so the next START cannot violate the bus-free time.

The command port is valid/ready. `cmd_ready` is high only while the master is idle, a command is taken on a cycle with both `cmd_valid` and `cmd_ready` high, and `cmd_ready` stays low until the command's done pulse. A host that cannot take a result has nothing to hold back: the results stay on their outputs until the next done pulse.

Top module: `twb_master`

## Requirements
- R1: During and after reset both pull enables are off, `cmd_ready` is high and `done_o` is low.
- R2: Opcodes are 0 = START, 1 = STOP, 2 = WRITE, 3 = READ_ACK, 4 = READ_LAST. Codes 5 to 7 complete with a done pulse two cycles after acceptance, cause no clock edge on the bus, and report timeout 0.
- R3: START releases data, releases clock and waits for it to read high, lowers data while the clock is high, waits 1 µs, then lowers the clock. It ends with both lines pulled low.
- R4: WRITE sends `cmd_data` most significant bit first, one clock pulse per bit. It then releases data for a ninth clock pulse and reports `ack_o` = 1 when data reads low during that high phase, else 0. It ends with the clock pulled low.
- R5: READ_ACK samples data once per clock high phase, most significant bit first, into `rd_data_o`. It pulls data low through a ninth clock pulse and releases data before done.
- R6: READ_LAST samples eight bits the same way, raises the clock a ninth time with data released (no acknowledge), and then performs a STOP.
- R7: STOP lowers the clock, lowers data, releases the clock and waits for it to rise, then releases data. Done follows no earlier than 60 µs after the data release.
- R8: While a target holds the clock low after a release, the master waits and then continues. The bytes sent and received are unaffected, and no timeout is reported.
- R9: If the clock stays low 1000 µs after a release, the command ends with `timeout_o` = 1, both pull enables off, and a done pulse no earlier than 1000 µs after acceptance.
- R10: `cmd_ready` is low from the cycle after acceptance until the done pulse. `done_o` lasts exactly one cycle. `rd_data_o`, `ack_o` and `timeout_o` hold their values until the next done pulse.
- R11: A released line reads high. The master pulls at most one line's enable per cycle, and the enables do not change while it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command will be taken |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_data | input | 8 | Byte to send for WRITE |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Byte received by the last read |
| ack_o | output | 1 | 1 when the last write was acknowledged |
| timeout_o | output | 1 | 1 when the last command hit the clock-stuck limit |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The bench puts a small target model on a wired-AND bus. The model answers writes with an acknowledge or a refusal and drives read bytes. A monitor records every bit at clock rises and every START and STOP edge. Some corner cases get their own tests:
- A refused write: a design that inverted the acknowledge sense would report success.
- Bit order: a design with the wrong order would send or assemble reversed bytes.
- A final read: a master that acknowledged it would leave the target driving data instead of seeing the stop.
- A clock held low for 20 µs on every pulse: a master that sampled on a fixed schedule would read stale data.
- A clock stuck low: a master without the limit would hang until the watchdog fired, and one that kept data pulled would wedge the bus.
- The STOP-to-done distance: a design that skipped the bus-free wait would finish far too early.

// File: rtl/twb_pkg.sv
package twb_pkg;

  // Command opcodes seen on cmd_op
  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_STOP    = 3'd1;
  localparam logic [2:0] OP_WRITE   = 3'd2;
  localparam logic [2:0] OP_RD_ACK  = 3'd3;
  localparam logic [2:0] OP_RD_LAST = 3'd4;

  localparam int unsigned STEP_W = 4;

  // One micro-step of a bus sequence
  typedef enum logic [2:0] {
    U_END,      // command complete
    U_SCL_LO,   // pull clock, hold
    U_SCL_REL,  // release clock, wait for it to rise
    U_SDA_LO,   // pull data, hold
    U_SDA_REL,  // release data, hold
    U_SDA_TX,   // put current transmit bit on data, hold
    U_SETUP,    // short wait with no line change
    U_BUSFREE   // bus-free wait after a stop
  } ukind_e;

  typedef struct packed {
    ukind_e              kind;
    logic                cap_rx;   // shift data into receive byte on rise
    logic                cap_ack;  // record acknowledge on rise
    logic                loop;     // repeat from 'back' while bits remain
    logic [STEP_W-1:0]   back;
  } uop_t;

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r[i] <= 1'b1;
            else        r[i] <= d;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r[i] <= 1'b1;
            else        r[i] <= r[i-1];
          end
        end
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/twb_ustimer.sv
module twb_ustimer #(
  parameter int CW      = 12,
  parameter int POLL_US = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] elapsed,
  output logic          poll
);
  localparam int PW = (POLL_US > 1) ? $clog2(POLL_US) : 1;

  logic [PW-1:0] pdiv;

  assign poll = tick && (pdiv == PW'(POLL_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      pdiv    <= '0;
    end else if (clr) begin
      elapsed <= '0;
      pdiv    <= '0;
    end else if (tick) begin
      if (elapsed != '1) elapsed <= elapsed + 1'b1;
      pdiv <= poll ? '0 : pdiv + 1'b1;
    end
  end
endmodule

// File: rtl/twb_uprog.sv
module twb_uprog
  import twb_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [STEP_W-1:0] idx,
  output uop_t              u
);
  function automatic uop_t mk(ukind_e k, logic rx, logic ak, logic lp, int b);
    uop_t r;
    r.kind    = k;
    r.cap_rx  = rx;
    r.cap_ack = ak;
    r.loop    = lp;
    r.back    = STEP_W'(b);
    return r;
  endfunction

  always_comb begin
    u = mk(U_END, 1'b0, 1'b0, 1'b0, 0);
    case (op)
      OP_START: begin
        case (idx)
          4'd0: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd1: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd2: u = mk(U_SDA_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd3: u = mk(U_SETUP,   1'b0, 1'b0, 1'b0, 0);
          4'd4: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b0, 0);
          default: ;
        endcase
      end
      OP_STOP: begin
        case (idx)
          4'd0: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd1: u = mk(U_SDA_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd2: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd3: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd4: u = mk(U_BUSFREE, 1'b0, 1'b0, 1'b0, 0);
          default: ;
        endcase
      end
      OP_WRITE: begin
        case (idx)
          4'd0: u = mk(U_SDA_TX,  1'b0, 1'b0, 1'b0, 0);
          4'd1: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd2: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b1, 0);
          4'd3: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd4: u = mk(U_SCL_REL, 1'b0, 1'b1, 1'b0, 0);
          4'd5: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b0, 0);
          default: ;
        endcase
      end
      OP_RD_ACK: begin
        case (idx)
          4'd0: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd1: u = mk(U_SCL_REL, 1'b1, 1'b0, 1'b0, 0);
          4'd2: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b1, 1);
          4'd3: u = mk(U_SDA_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd4: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd5: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd6: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          default: ;
        endcase
      end
      OP_RD_LAST: begin
        case (idx)
          4'd0: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd1: u = mk(U_SCL_REL, 1'b1, 1'b0, 1'b0, 0);
          4'd2: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b1, 1);
          4'd3: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd4: u = mk(U_SCL_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd5: u = mk(U_SDA_LO,  1'b0, 1'b0, 1'b0, 0);
          4'd6: u = mk(U_SCL_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd7: u = mk(U_SDA_REL, 1'b0, 1'b0, 1'b0, 0);
          4'd8: u = mk(U_BUSFREE, 1'b0, 1'b0, 1'b0, 0);
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/twb_master.sv
module twb_master
  import twb_pkg::*;
#(
  parameter int TIMEOUT_US  = 1000,
  parameter int BUSFREE_US  = 60,
  parameter int HOLD_US     = 2,
  parameter int SETUP_US    = 1,
  parameter int POLL_US     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       done_o,
  output logic [7:0] rd_data_o,
  output logic       ack_o,
  output logic       timeout_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o
);
  localparam int LIM_A = (TIMEOUT_US > BUSFREE_US) ? TIMEOUT_US : BUSFREE_US;
  localparam int LIM_B = (HOLD_US > SETUP_US) ? HOLD_US : SETUP_US;
  localparam int LIM   = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW    = $clog2(LIM + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT} st_e;

  st_e               st;
  logic [2:0]        op_q;
  logic [7:0]        tx_q;
  logic [7:0]        rx_q;
  logic [2:0]        bit_q;
  logic [STEP_W-1:0] idx_q;
  logic              ack_q;
  logic              scl_s, sda_s;
  logic [CW-1:0]     elapsed;
  logic              poll;
  uop_t              u;
  logic              hold_met;

  twb_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );
  twb_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  twb_ustimer #(.CW(CW), .POLL_US(POLL_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st == S_EXEC), .tick(us_tick),
    .elapsed(elapsed), .poll(poll)
  );

  twb_uprog u_prog (.op(op_q), .idx(idx_q), .u(u));

  assign cmd_ready = (st == S_IDLE);

  // Wait length of the current step (clock release handled apart)
  always_comb begin
    case (u.kind)
      U_SETUP:   hold_met = (elapsed >= CW'(SETUP_US));
      U_BUSFREE: hold_met = (elapsed >= CW'(BUSFREE_US));
      default:   hold_met = (elapsed >= CW'(HOLD_US));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      bit_q      <= 3'd7;
      idx_q      <= '0;
      ack_q      <= 1'b0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
      done_o     <= 1'b0;
      rd_data_o  <= '0;
      ack_o      <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q  <= cmd_op;
            tx_q  <= cmd_data;
            rx_q  <= '0;
            bit_q <= 3'd7;
            idx_q <= '0;
            ack_q <= 1'b0;
            st    <= S_EXEC;
          end
        end

        S_EXEC: begin
          st <= S_WAIT;
          case (u.kind)
            U_SCL_LO:  scl_pull_o <= 1'b1;
            U_SCL_REL: scl_pull_o <= 1'b0;
            U_SDA_LO:  sda_pull_o <= 1'b1;
            U_SDA_REL: sda_pull_o <= 1'b0;
            U_SDA_TX:  sda_pull_o <= !tx_q[bit_q];
            U_END: begin
              done_o    <= 1'b1;
              rd_data_o <= rx_q;
              ack_o     <= ack_q;
              timeout_o <= 1'b0;
              st        <= S_IDLE;
            end
            default: ;
          endcase
        end

        S_WAIT: begin
          if (u.kind == U_SCL_REL) begin
            if (poll) begin
              if (scl_s) begin
                if (u.cap_rx)  rx_q  <= {rx_q[6:0], sda_s};
                if (u.cap_ack) ack_q <= !sda_s;
                idx_q <= idx_q + 1'b1;
                st    <= S_EXEC;
              end else if (elapsed >= CW'(TIMEOUT_US - 1)) begin
                scl_pull_o <= 1'b0;
                sda_pull_o <= 1'b0;
                done_o     <= 1'b1;
                rd_data_o  <= rx_q;
                ack_o      <= 1'b0;
                timeout_o  <= 1'b1;
                st         <= S_IDLE;
              end
            end
          end else if (hold_met) begin
            st <= S_EXEC;
            if (u.loop && bit_q != 3'd0) begin
              bit_q <= bit_q - 1'b1;
              idx_q <= u.back;
            end else begin
              if (u.loop) bit_q <= 3'd7;
              idx_q <= idx_q + 1'b1;
            end
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twb_master_chk.sv
module twb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done_o,
  input logic timeout_o,
  input logic scl_pull_o,
  input logic sda_pull_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cmd_ready);

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> done_o);

  // R11
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_pull_o) |-> $stable(sda_pull_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && $past(cmd_ready)) |-> ($stable(scl_pull_o) && $stable(sda_pull_o)));
endmodule

bind twb_master twb_master_chk u_twb_master_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done_o(done_o), .timeout_o(timeout_o),
  .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o)
);

// File: tb/twb_master_bench.sv
module twb_master_bench;
  localparam int TICK_DIV = 4;
  localparam int WD_LIMIT = 150000;
  localparam int TMO_US   = 1000;
  localparam int FREE_US  = 60;
  localparam int M_NONE = 0, M_WACK = 1, M_WNAK = 2, M_RD = 3;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] dat;
    logic [1:0] mode;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{3'd0, 8'h00, 2'd0},
    '{3'd2, 8'hA6, 2'd1},
    '{3'd2, 8'h5C, 2'd1},
    '{3'd0, 8'h00, 2'd0},
    '{3'd2, 8'hA7, 2'd1},
    '{3'd3, 8'h3B, 2'd3},
    '{3'd3, 8'hC4, 2'd3},
    '{3'd4, 8'h96, 2'd3},
    '{3'd0, 8'h00, 2'd0},
    '{3'd2, 8'h0F, 2'd2},
    '{3'd1, 8'h00, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, done_o, ack_o, timeout_o, m_scl, m_sda;
  logic [7:0] rd_data_o;

  int cyc = 0, tdiv = 0;
  int rise_cnt = 0, fall_cnt = 0, start_cnt = 0, stop_cnt = 0, stop_cyc = 0;
  int rise_base = 0, fall_base = 0;
  int tgt_mode = 0;
  logic [7:0] tgt_byte = '0;
  int stretch_cyc = 0, rel_cyc = 0;
  logic stuck = 1'b0;
  logic [15:0] seen = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int n_chk = 0, n_fail = 0;
  logic wd_hit = 1'b0;
  logic rdy_after = 1'b1;

  int fall_rel;
  logic tgt_sda, tgt_scl, scl_b, sda_b;
  assign fall_rel = fall_cnt - fall_base;
  assign tgt_scl = stuck || (!m_scl && rel_cyc < stretch_cyc);
  always_comb begin
    tgt_sda = 1'b0;
    if ((tgt_mode == M_WACK) && fall_rel == 8) tgt_sda = 1'b1;
    if ((tgt_mode == M_RD) && fall_rel >= 0 && fall_rel < 8)
      tgt_sda = !tgt_byte[7 - fall_rel];
  end
  assign scl_b = !(m_scl || tgt_scl);
  assign sda_b = !(m_sda || tgt_sda);

  always #2.5 clk = !clk;

  twb_master u_twb_master (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .done_o(done_o), .rd_data_o(rd_data_o), .ack_o(ack_o), .timeout_o(timeout_o),
    .scl_i(scl_b), .sda_i(sda_b), .scl_pull_o(m_scl), .sda_pull_o(m_sda)
  );

  // Bus monitor, tick source and stretch counter, all away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    us_tick <= (tdiv == TICK_DIV - 1);
    rel_cyc <= m_scl ? 0 : rel_cyc + 1;
    if (scl_b && !prev_scl) begin
      if ((rise_cnt - rise_base) >= 0 && (rise_cnt - rise_base) < 16)
        seen[rise_cnt - rise_base] <= sda_b;
      rise_cnt <= rise_cnt + 1;
    end
    if (!scl_b && prev_scl) fall_cnt <= fall_cnt + 1;
    if (scl_b && prev_scl && !sda_b && prev_sda) start_cnt <= start_cnt + 1;
    if (scl_b && prev_scl && sda_b && !prev_sda) begin
      stop_cnt <= stop_cnt + 1;
      stop_cyc <= cyc;
    end
    prev_scl <= scl_b;
    prev_sda <= sda_b;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] seen_byte();
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = seen[k];
    return b;
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input int mode,
                         output int cycles);
    int t0;
    @(negedge clk);
    while (!cmd_ready && cyc < WD_LIMIT) @(negedge clk);
    rise_base = rise_cnt;
    fall_base = fall_cnt;
    tgt_mode  = mode;
    tgt_byte  = d;
    cmd_op    = op;
    cmd_data  = d;
    cmd_valid = 1'b1;
    t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    rdy_after = cmd_ready;
    while (!done_o && cyc < WD_LIMIT) @(negedge clk);
    if (cyc >= WD_LIMIT) wd_hit = 1'b1;
    cycles = cyc - t0;
    @(negedge clk);
    tgt_mode = M_NONE;
  endtask

  initial begin
    int cy, s0, p0, r0;
    logic [7:0] held;
    repeat (5) @(negedge clk);
    // R1 reset state, R11 released lines read high
    chk(!m_scl && !m_sda, "R1", {m_scl, m_sda}, 0);
    chk(cmd_ready && !done_o, "R1", {cmd_ready, done_o}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_b && sda_b, "R11", {scl_b, sda_b}, 3);

    // Table-driven walk
    for (int v = 0; v < NV; v++) begin
      s0 = start_cnt; p0 = stop_cnt;
      run_cmd(VEC[v].op, VEC[v].dat, int'(VEC[v].mode), cy);
      chk(!timeout_o, "R10", timeout_o, 0);
      case (VEC[v].op)
        3'd0: begin // R3
          chk(start_cnt - s0 == 1, "R3", start_cnt - s0, 1);
          chk(m_scl && m_sda, "R3", {m_scl, m_sda}, 3);
        end
        3'd2: begin // R4
          chk(seen_byte() == VEC[v].dat, "R4", seen_byte(), VEC[v].dat);
          chk(ack_o == (VEC[v].mode == 2'd1), "R4", ack_o, VEC[v].mode == 2'd1);
          chk(m_scl, "R4", m_scl, 1);
        end
        3'd3: begin // R5
          chk(rd_data_o == VEC[v].dat, "R5", rd_data_o, VEC[v].dat);
          chk(seen[8] == 1'b0 && !m_sda, "R5", {seen[8], m_sda}, 0);
        end
        3'd4: begin // R6
          chk(rd_data_o == VEC[v].dat, "R6", rd_data_o, VEC[v].dat);
          chk(seen[8] == 1'b1 && stop_cnt - p0 == 1, "R6", {seen[8], 4'(stop_cnt - p0)}, 8'h11);
        end
        default: begin // R7
          chk(stop_cnt - p0 == 1, "R7", stop_cnt - p0, 1);
          chk(cyc - 1 - stop_cyc >= FREE_US * TICK_DIV, "R7", cyc - 1 - stop_cyc, FREE_US * TICK_DIV);
        end
      endcase
    end

    // R10: results hold until next done, ready drops after acceptance
    held = rd_data_o;
    repeat (20) @(negedge clk);
    chk(rd_data_o == held && !done_o, "R10", rd_data_o, held);
    chk(rdy_after == 1'b0, "R10", rdy_after, 0);

    // R2: unused opcode finishes at once with no clock edge
    r0 = rise_cnt;
    run_cmd(3'd6, 8'hFF, M_NONE, cy);
    chk(cy == 2, "R2", cy, 2);
    chk(rise_cnt == r0 && !timeout_o, "R2", rise_cnt - r0, 0);

    // R8: target stretches every clock high phase by 20 us
    stretch_cyc = 20 * TICK_DIV;
    run_cmd(3'd0, 8'h00, M_NONE, cy);
    run_cmd(3'd2, 8'h3C, M_WACK, cy);
    chk(seen_byte() == 8'h3C && ack_o, "R8", seen_byte(), 8'h3C);
    chk(cy > 9 * stretch_cyc && !timeout_o, "R8", cy, 9 * stretch_cyc);
    run_cmd(3'd4, 8'h69, M_RD, cy);
    chk(rd_data_o == 8'h69 && !timeout_o, "R8", rd_data_o, 8'h69);
    stretch_cyc = 0;

    // R9: clock stuck low during a write
    run_cmd(3'd0, 8'h00, M_NONE, cy);
    stuck = 1'b1;
    run_cmd(3'd2, 8'h55, M_WACK, cy);
    chk(timeout_o == 1'b1, "R9", timeout_o, 1);
    chk(!m_scl && !m_sda, "R9", {m_scl, m_sda}, 0);
    chk(cy >= TMO_US * TICK_DIV, "R9", cy, TMO_US * TICK_DIV);
    stuck = 1'b0;
    repeat (10) @(negedge clk);
    p0 = stop_cnt;
    run_cmd(3'd1, 8'h00, M_NONE, cy);
    chk(!timeout_o && stop_cnt - p0 == 1, "R9", {timeout_o, 4'(stop_cnt - p0)}, 1);

    if (wd_hit) chk(1'b0, "watchdog", cyc, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // Hard stop for a run that never reaches its checks
  initial begin
    #(WD_LIMIT * 5 + 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule